// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital control side of an eight-input, 12-bit successive-approximation converter with a synchronous serial port. Every action is timed by the serial clock. A frame starts when a 1 is seen on the serial input. Seven more control bits follow it. They set the input multiplexer, the input mode (single-ended against common, or a differential pair) and the power policy. The block then opens the sampling window, moves to hold, and runs twelve bit trials against an external comparator. The result leaves MSB first on the serial output.

The multiplexer, the capacitor DAC and the comparator are outside the block. The block drives the channel selects, a sampling strobe and the trial word for the DAC. It reads one comparator decision per rising clock edge. A new control byte may overlap the readout of the previous result, so a conversion can complete every 15 or 16 clocks. While chip select is high the block ignores the port, and the output enables tell the pad ring to float the serial output and the busy flag.

Top module: `sar_serial_seq`

## Requirements
- R1: While no frame is running, zeros on `din` are ignored. The first rising `dclk` edge with `din`=1 and `cs_n`=0 is frame edge 1, and it marks the start.
- R2: The control byte is sampled on rising edges 1..8, MSB first. Bit 7 is the start bit. Bits 6..4 are the address a2,a1,a0. Bit 3 is ignored. Bit 2 selects the mode (1 = single-ended). Bits 1..0 are the power code.
- R3: In single-ended mode, `pos_ch` = {a1,a0,a2} (for example, address 100 selects input 1 and 001 selects input 2), and `neg_com`=1.
- R4: In differential mode, `neg_com`=0. Address a2=0 gives `pos_ch`=2p and `neg_ch`=2p+1, where p={a1,a0}. Address a2=1 gives the same pair with the polarity reversed.
- R5: The selects and `sample_en`=1 update at rising edge 6. `sample_en` stays high through edge 7 and falls at edge 8 (hold). The selects do not change until the conversion is done.
- R6: At edge 8, `dac_code` becomes 0x800. At each of edges 9..20 the current trial bit is kept if `cmp_in`=1 and cleared if `cmp_in`=0, and the next lower bit is set. The result is the straight-binary code of the input.
- R7: `busy` goes high at falling edge 8 and low at falling edge 9. It is high at no other time.
- R8: `dout` presents result bit 11 at falling edge 9, down to bit 0 at falling edge 20. After that it is 0 until the next result.
- R9: A start bit is accepted again from rising edge 16 of a running frame. Ones on `din` at edges 9..15 are ignored. Frames spaced 15 or 16 clocks apart each give correct results.
- R10: While `cs_n`=1, `dout_oe` and `busy_oe` are 0, and the clock and data are ignored. The frame state is frozen.
- R11: `pwr_down` is 1 whenever `shdn_n`=0. With power code 00 it also rises after the LSB has been driven (from rising edge 21) and falls at the next start bit. Codes 11, 01 and 10 never power down.
- R12: After reset: `busy`=0, `dout`=0, `sample_en`=0, `dac_code`=0, `neg_com`=1, `pwr_down`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial and conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial control input, sampled on rising edges |
| shdn_n | input | 1 | Forced shutdown, active low |
| cmp_in | input | 1 | Comparator decision, 1 when input >= DAC level |
| dac_code | output | 12 | Trial word for the capacitor DAC |
| sample_en | output | 1 | Sampling switch closed (acquire) |
| pos_ch | output | 3 | Positive multiplexer input index |
| neg_ch | output | 3 | Negative multiplexer input index (differential) |
| neg_com | output | 1 | Negative side tied to the common pin |
| dout | output | 1 | Serial result, changes on falling edges |
| dout_oe | output | 1 | Drive enable for dout |
| busy | output | 1 | Conversion pending flag |
| busy_oe | output | 1 | Drive enable for busy |
| pwr_down | output | 1 | Analog section powered down |

## Verification
The hardest state to reach is a new frame starting on edge 16 of the previous one. At that point the old result's low bits are still shifting out on falling edges while the new control bits arrive on rising edges. The bench drives a global schedule of frames 15 and 16 clocks apart. It works out, for every edge, which frame owns that edge, and checks the sampling strobe, the busy pulse and each result bit against the frame it belongs to. A second pattern puts ones on `din` in the window where a start bit must not be accepted. It then checks that framing and results are unaffected.

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int RES        = 12,
  parameter int HUNT_AFTER = 15
) (
  input  logic           dclk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           din,
  input  logic           shdn_n,
  input  logic           cmp_in,
  output logic [RES-1:0] dac_code,
  output logic           sample_en,
  output logic [2:0]     pos_ch,
  output logic [2:0]     neg_ch,
  output logic           neg_com,
  output logic           dout,
  output logic           dout_oe,
  output logic           busy,
  output logic           busy_oe,
  output logic           pwr_down
);
  localparam int SW = $clog2(RES + 2);
  localparam int FW = $clog2(HUNT_AFTER + 2);
  localparam logic [SW-1:0] DONE = SW'(RES + 1);
  localparam logic [RES-1:0] TRIAL = RES'(1) << (RES - 1);

  logic [FW-1:0] fcnt_q, fcnt_d;
  logic [6:0]    ctl_q;
  logic [SW-1:0] step_q, tidx, oidx;
  logic          auto_q, busy_q, dout_q;
  logic          hunt, start;

  assign hunt  = (fcnt_q == '0) || (fcnt_q >= FW'(HUNT_AFTER));
  assign start = hunt && din;
  assign tidx  = SW'(RES - 1) - step_q;
  assign oidx  = SW'(RES) - step_q;

  always_comb begin
    fcnt_d = fcnt_q;
    if (start)
      fcnt_d = FW'(1);
    else if (fcnt_q != '0 && fcnt_q != '1)
      fcnt_d = fcnt_q + 1'b1;
  end

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q    <= '0;
      ctl_q     <= '0;
      sample_en <= 1'b0;
      pos_ch    <= '0;
      neg_ch    <= '0;
      neg_com   <= 1'b1;
      auto_q    <= 1'b0;
      dac_code  <= '0;
      step_q    <= DONE;
    end else if (!cs_n) begin
      fcnt_q <= fcnt_d;
      if (fcnt_d >= FW'(2) && fcnt_d <= FW'(8))
        ctl_q <= {ctl_q[5:0], din};
      if (fcnt_d == FW'(6)) begin
        sample_en <= 1'b1;
        pos_ch    <= {ctl_q[2], ctl_q[1], ctl_q[3]};
        neg_ch    <= din ? 3'd0 : {ctl_q[2], ctl_q[1], ~ctl_q[3]};
        neg_com   <= din;
      end
      if (fcnt_d == FW'(8)) begin
        sample_en <= 1'b0;
        auto_q    <= ~ctl_q[0] & ~din;
        dac_code  <= TRIAL;
        step_q    <= '0;
      end else if (step_q < SW'(RES)) begin
        if (!cmp_in)
          dac_code[tidx] <= 1'b0;
        if (tidx != '0)
          dac_code[tidx - 1'b1] <= 1'b1;
        step_q <= step_q + 1'b1;
      end else if (step_q == SW'(RES)) begin
        step_q <= DONE;
      end
    end
  end

  always_ff @(negedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dout_q <= 1'b0;
    end else if (!cs_n) begin
      busy_q <= (step_q == '0);
      dout_q <= (step_q != '0 && step_q <= SW'(RES)) ? dac_code[oidx] : 1'b0;
    end
  end

  assign busy     = busy_q;
  assign dout     = dout_q;
  assign dout_oe  = !cs_n;
  assign busy_oe  = !cs_n;
  assign pwr_down = !shdn_n || (auto_q && step_q == DONE && hunt);

  // R1
  start_seen_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    (fcnt_q == FW'(1) && $past(fcnt_q) != FW'(1)) |-> $past(din && !cs_n));

  // R7
  busy_pulse_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    busy_q |-> step_q == '0);

  // R5
  hold_apart_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    !(sample_en && busy_q));

  // R5
  mux_frozen_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    (step_q < SW'(RES)) |-> ($stable(pos_ch) && $stable(neg_com) && $stable(neg_ch)));

  // R6
  trial_bit_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    (step_q < SW'(RES)) |-> dac_code[tidx]);

  // R8
  zero_fill_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    (step_q == DONE && $past(step_q) == DONE && !cs_n && $past(!cs_n)) |-> !dout_q);

  // R11
  awake_busy_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    (pwr_down && shdn_n) |-> (!busy_q && !sample_en));
endmodule

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;
  logic dclk = 1'b0, rst_n, cs_n, din, shdn_n, cmp_in;
  logic [11:0] dac_code, vin;
  logic sample_en, neg_com, dout, dout_oe, busy, busy_oe, pwr_down;
  logic [2:0] pos_ch, neg_ch;
  int checks = 0, errors = 0;
  logic [7:0]  ctl_a [8];
  logic [11:0] v_a   [8];

  always #2.5 dclk = ~dclk;
  assign cmp_in = (vin >= dac_code);

  sar_serial_seq u_dut (
    .dclk(dclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .shdn_n(shdn_n),
    .cmp_in(cmp_in), .dac_code(dac_code), .sample_en(sample_en),
    .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_com(neg_com), .dout(dout),
    .dout_oe(dout_oe), .busy(busy), .busy_oe(busy_oe), .pwr_down(pwr_down));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_mux(input logic [7:0] c, output int p, output int n);
    if (c[2]) begin
      case (c[6:4])
        3'b000: p = 0; 3'b100: p = 1; 3'b001: p = 2; 3'b101: p = 3;
        3'b010: p = 4; 3'b110: p = 5; 3'b011: p = 6; default: p = 7;
      endcase
      n = 0;
    end else begin
      case (c[6:4])
        3'b000: begin p = 0; n = 1; end
        3'b001: begin p = 2; n = 3; end
        3'b010: begin p = 4; n = 5; end
        3'b011: begin p = 6; n = 7; end
        3'b100: begin p = 1; n = 0; end
        3'b101: begin p = 3; n = 2; end
        3'b110: begin p = 5; n = 4; end
        default: begin p = 7; n = 6; end
      endcase
    end
  endfunction

  // Starts just after a falling edge and ends just after one.
  task automatic stream(input int n, input int period, input int lead, input bit junk);
    logic [11:0] got [8];
    int total;
    total = lead + (n - 1) * period + 24;
    for (int f = 0; f < 8; f++) got[f] = '0;
    for (int t = 1; t <= total; t++) begin
      logic d;
      logic eb, ed;
      d = 1'b0;
      for (int f = 0; f < n; f++) begin
        int p;
        p = t - lead - f * period;
        if (p >= 1 && p <= 8) d = ctl_a[f][8-p];
        if (junk && p >= 9 && p <= 15) d = 1'b1;
        if (p >= 9 && p <= 20) vin = v_a[f];
      end
      din = d;
      @(posedge dclk); #1;
      for (int f = 0; f < n; f++) begin
        int p, ep, en;
        p = t - lead - f * period;
        if (p == 1) chk("R11", "wake at start", pwr_down, 0);
        if (p == 6) begin
          exp_mux(ctl_a[f], ep, en);
          chk("R5", "sample_en edge6", sample_en, 1);
          if (ctl_a[f][2]) begin
            chk("R3", "pos_ch", pos_ch, ep);
            chk("R3", "neg_com", neg_com, 1);
          end else begin
            chk("R4", "pos_ch", pos_ch, ep);
            chk("R4", "neg_ch", neg_ch, en);
            chk("R4", "neg_com", neg_com, 0);
          end
        end
        if (p == 7) chk("R5", "sample_en edge7", sample_en, 1);
        if (p == 8) begin
          chk("R5", "hold at edge8", sample_en, 0);
          chk("R6", "first trial", dac_code, 12'h800);
        end
        if (p >= 9 && p <= 20) chk("R11", "awake converting", pwr_down, 0);
      end
      @(negedge dclk); #1;
      eb = 1'b0; ed = 1'b0;
      for (int f = 0; f < n; f++) begin
        int p;
        p = t - lead - f * period;
        if (p == 8) eb = 1'b1;
        if (p >= 9 && p <= 20) begin
          ed = v_a[f][20-p];
          got[f][20-p] = dout;
        end
      end
      chk("R7", "busy", busy, eb);
      chk("R8", "dout bit", dout, ed);
    end
    for (int f = 0; f < n; f++) chk(period < 24 ? "R9" : "R6", "result word", got[f], v_a[f]);
  endtask

  task automatic test_reset();
    chk("R12", "busy", busy, 0);
    chk("R12", "dout", dout, 0);
    chk("R12", "sample_en", sample_en, 0);
    chk("R12", "dac_code", dac_code, 0);
    chk("R12", "neg_com", neg_com, 1);
    chk("R12", "pwr_down", pwr_down, 0);
    chk("R10", "dout_oe with cs high", dout_oe, 0);
  endtask

  task automatic test_basic();
    ctl_a[0] = 8'b1001_0111; v_a[0] = 12'hA5C;
    stream(1, 24, 5, 1'b0);   // R1 leading zeros ignored
    chk("R11", "code 11 stays up", pwr_down, 0);
  endtask

  task automatic test_single_all();
    for (int i = 0; i < 8; i++) begin
      ctl_a[i] = {1'b1, 3'(i), 1'(i), 1'b1, 2'b11};  // R2 bit3 toggled, ignored
      v_a[i] = 12'(i * 12'h1F3 + 12'h15);
    end
    v_a[0] = 12'h000; v_a[7] = 12'hFFF;
    stream(8, 24, 0, 1'b0);
  endtask

  task automatic test_diff16();
    for (int i = 0; i < 8; i++) begin
      ctl_a[i] = {1'b1, 3'(i), 1'b0, 1'b0, 2'b11};
      v_a[i] = 12'hFFF - 12'(i * 12'h123);
    end
    ctl_a[7][1:0] = 2'b00;
    stream(8, 16, 2, 1'b0);
    chk("R11", "auto power-down after LSB", pwr_down, 1);
  endtask

  task automatic test_overlap15();
    for (int i = 0; i < 4; i++) begin
      ctl_a[i] = {1'b1, 3'(7 - i), 1'b0, 1'(i), 2'b11};
      v_a[i] = 12'(12'h3C7 * (i + 1));
    end
    stream(4, 15, 0, 1'b0);
    chk("R9", "no power-down code 11", pwr_down, 0);
  endtask

  task automatic test_early_ones();
    ctl_a[0] = 8'b1111_0101; v_a[0] = 12'h7FF;
    stream(1, 24, 0, 1'b1);   // R9 ones on edges 9..15
    chk("R2", "reserved code 01 stays up", pwr_down, 0);
    ctl_a[0] = 8'b1010_0010; v_a[0] = 12'h801;
    stream(1, 24, 0, 1'b0);
    chk("R11", "reserved code 10 stays up", pwr_down, 0);
  endtask

  task automatic test_cs_ignore();
    logic [2:0] p0;
    logic c0;
    p0 = pos_ch; c0 = neg_com;
    cs_n = 1'b1; din = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge dclk); #1;
      chk("R10", "dout_oe", dout_oe, 0);
      chk("R10", "busy_oe", busy_oe, 0);
      @(negedge dclk); #1;
    end
    chk("R10", "pos_ch frozen", pos_ch, p0);
    chk("R10", "neg_com frozen", neg_com, c0);
    cs_n = 1'b0; din = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge dclk); #1;
      chk("R10", "no busy after cs", busy, 0);
    end
    chk("R10", "dout_oe active", dout_oe, 1);
    ctl_a[0] = 8'b1110_0011; v_a[0] = 12'h0F0;
    stream(1, 24, 1, 1'b0);
  endtask

  task automatic test_shutdown();
    shdn_n = 1'b0; #1;
    chk("R11", "shutdown forces power-down", pwr_down, 1);
    shdn_n = 1'b1; #1;
    chk("R11", "shutdown released", pwr_down, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; din = 1'b0; shdn_n = 1'b1; vin = '0;
    repeat (3) @(negedge dclk);
    rst_n = 1'b1; #1;
    test_reset();
    @(negedge dclk); #1;
    cs_n = 1'b0;
    test_basic();
    test_single_all();
    test_diff16();
    test_overlap15();
    test_early_ones();
    test_cs_ignore();
    test_shutdown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule